// File: doc/BRIEF.md
# USB Endpoint Control Bank with Data-Toggle Tracking

This block holds the per-endpoint configuration of a USB device controller and keeps track of the DATA0/DATA1 sequence seen on each endpoint. Software picks an endpoint by writing a small endpoint-number register. It then reads or writes that endpoint's 8-bit control byte, which holds an enable bit, a direction bit and a two-bit transfer type. A packet engine reports each received data packet with a one-cycle strobe. The strobe carries the endpoint number, the PID parity (DATA1 = 1) and a flag that marks a SETUP transaction.

For each accepted packet the block updates a read-only toggle status bit. Every tracked endpoint also keeps an internal expected parity. A packet whose parity differs from that expectation is a host retry, and the block flags it on `pkt_dup` in the same cycle as the strobe, so the packet engine can drop the payload. Isochronous endpoints never flag a duplicate. On a control endpoint, a SETUP packet restarts the sequence. The sequence also restarts on any configuration write that sets the enable bit. The event port is a plain strobe with no back-pressure: every strobe is consumed in the cycle it is presented.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: After `rst_n` is released, every control byte reads 0x00 and the endpoint-number register reads 0.
- R2: Control byte layout: bit 7 enable, bit 3 toggle status, bit 2 direction (1 = IN), bits 1:0 type (00 control, 01 isochronous, 10 bulk, 11 interrupt). Bits 6:4 always read 0. Writes to bits 6:3 have no effect.
- R3: With `reg_sel`=0, a write loads the endpoint number from `reg_wdata[2:0]` and a read returns it zero-extended. With `reg_sel`=1, the byte of the selected endpoint is accessed. An endpoint at or above NUM_EP (default 6) reads 0x00 and ignores writes.
- R4: An accepted packet on an enabled endpoint sets the toggle status to its PID parity one cycle after the strobe: DATA1 sets it, DATA0 clears it. The exception is a control SETUP, covered by R7.
- R5: On control, bulk and interrupt endpoints, `pkt_dup` is 1 in the strobe cycle when the parity differs from the expected parity. The expected parity is DATA0 after configuration, and after each packet it is the inverse of that packet's parity.
- R6: An isochronous endpoint never raises `pkt_dup`, and its toggle status still follows the received parity.
- R7: A SETUP-flagged packet on a control endpoint never raises `pkt_dup`. It clears the toggle status and makes DATA1 the expected parity.
- R8: A control-byte write with bit 7 set resets the toggle status and the expected parity to DATA0. A write with bit 7 clear leaves both unchanged.
- R9: Packets for a disabled or unimplemented endpoint change nothing and raise no `pkt_dup`.
- R10: `bus_rst` high for one cycle returns all control bytes and toggle histories to reset at the next edge. The endpoint-number register is kept. A strobe in that cycle raises no `pkt_dup`.
- R11: The direction bit has no effect on toggle tracking or on duplicate detection.
- R12: When a configuration write with bit 7 set and a packet for the same endpoint occur in the same cycle, `pkt_dup` is judged on the old state, and the write's toggle reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous USB bus reset, clears all endpoint entries |
| reg_sel | input | 1 | 0 selects the endpoint-number register, 1 selects the control byte |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pkt_stb | input | 1 | One-cycle packet-received strobe |
| pkt_ep | input | 3 | Endpoint number of the packet |
| pkt_data1 | input | 1 | PID parity: 1 = DATA1, 0 = DATA0 |
| pkt_setup | input | 1 | Packet belongs to a SETUP transaction |
| pkt_dup | output | 1 | Duplicate-packet flag, valid in the strobe cycle |

## Verification
The hardest case to reach from the ports is a configuration write and a packet strobe hitting the same endpoint in the same cycle. Here the duplicate decision must use the pre-write state, while the stored toggle must take the write's reset. The bench forces this collision directly. It also arises in the random phase, because each cycle there may carry a register write and a packet event together. A bench model checks `pkt_dup` in every strobe cycle and the read-back bytes against its own endpoint table.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    EP_CTRL = 2'b00,
    EP_ISO  = 2'b01,
    EP_BULK = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  typedef struct packed {
    logic     en;
    logic     dir;
    ep_kind_e kind;
    logic     tgl;
    logic     exp_d1;
  } ep_state_t;

  localparam int EN_POS  = 7;
  localparam int TGL_POS = 3;
  localparam int DIR_POS = 2;

  function automatic logic [7:0] ep_view(input ep_state_t s);
    logic [7:0] v;
    v = '0;
    v[EN_POS]  = s.en;
    v[TGL_POS] = s.tgl;
    v[DIR_POS] = s.dir;
    v[1:0]     = s.kind;
    return v;
  endfunction

endpackage

// File: rtl/usb_ep_event_decode.sv
module usb_ep_event_decode #(
  parameter int NUM_EP = 6,
  parameter int EPN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_stb,
  input  logic [EPN_W-1:0]  pkt_ep,
  input  logic              bus_rst,
  output logic [NUM_EP-1:0] hit
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_hit
    assign hit[i] = pkt_stb && !bus_rst && (pkt_ep == EPN_W'(i));
  end

  // R9: at most one entry sees any event; R10: bus reset masks all
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  a_r10_bus_masks_events: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (hit == '0));

endmodule

// File: rtl/usb_ep_entry.sv
module usb_ep_entry
  import usb_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_rst,
  input  logic     cfg_wr,
  input  logic     cfg_en,
  input  logic     cfg_dir,
  input  ep_kind_e cfg_kind,
  input  logic     hit,
  input  logic     pid_d1,
  input  logic     setup,
  output logic [7:0] view,
  output logic     dup
);

  ep_state_t st;
  logic accept, setup_ctrl, tracked;

  assign accept     = hit && st.en;
  assign setup_ctrl = accept && (st.kind == EP_CTRL) && setup;
  assign tracked    = (st.kind != EP_ISO);
  assign dup        = accept && tracked && !setup_ctrl && (pid_d1 != st.exp_d1);
  assign view       = ep_view(st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (bus_rst) begin
      st <= '0;
    end else begin
      if (accept) begin
        if (setup_ctrl) begin
          st.tgl    <= 1'b0;
          st.exp_d1 <= 1'b1;
        end else begin
          st.tgl    <= pid_d1;
          st.exp_d1 <= ~pid_d1;
        end
      end
      if (cfg_wr) begin
        st.en   <= cfg_en;
        st.dir  <= cfg_dir;
        st.kind <= cfg_kind;
        if (cfg_en) begin
          st.tgl    <= 1'b0;
          st.exp_d1 <= 1'b0;
        end
      end
    end
  end

  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !st.en |-> !dup);
  a_r6_iso_never_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (st.kind == EP_ISO) |-> !dup);
  a_r7_setup_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_ctrl && !cfg_wr && !bus_rst) |=> (!st.tgl && st.exp_d1));
  a_r7_setup_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    setup_ctrl |-> !dup);
  a_r8_cfg_resets_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en && !bus_rst) |=> (!st.tgl && !st.exp_d1));
  a_r4_toggle_follows_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !setup_ctrl && !cfg_wr && !bus_rst) |=> (st.tgl == $past(pid_d1)));
  a_r10_bus_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (view == 8'h00));

endmodule

// File: rtl/usb_ep_cpu_port.sv
module usb_ep_cpu_port #(
  parameter int NUM_EP = 6,
  parameter int EPN_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_sel,
  input  logic                   reg_wr,
  input  logic [7:0]             reg_wdata,
  input  logic [NUM_EP-1:0][7:0] views,
  output logic [NUM_EP-1:0]      cfg_wr,
  output logic [7:0]             reg_rdata
);

  localparam int EP_SPACE = 1 << EPN_W;

  logic [EPN_W-1:0] epnum;
  logic [7:0]       sel_view;
  logic             rsvd_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  epnum <= '0;
    else if (reg_wr && !reg_sel) epnum <= reg_wdata[EPN_W-1:0];
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_wsel
    assign cfg_wr[i] = reg_wr && reg_sel && (epnum == EPN_W'(i));
  end

  always_comb begin
    sel_view = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (epnum == EPN_W'(i)) sel_view = views[i];
    end
  end

  assign reg_rdata  = reg_sel ? sel_view : 8'(epnum);
  assign rsvd_write = reg_wr && reg_sel && (|reg_wdata[6:4]);

  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[6:4] == 3'b000));
  a_r2_reserved_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_write |=> (views[0][6:4] == 3'b000));
  a_r3_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && (int'(epnum) >= NUM_EP)) |-> (reg_rdata == 8'h00));
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr));

  initial begin
    assert (NUM_EP >= 1 && NUM_EP <= EP_SPACE)
      else $error("NUM_EP out of range");
  end

endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int EPN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             pkt_stb,
  input  logic [EPN_W-1:0] pkt_ep,
  input  logic             pkt_data1,
  input  logic             pkt_setup,
  output logic             pkt_dup
);

  logic [NUM_EP-1:0][7:0] views;
  logic [NUM_EP-1:0]      cfg_wr;
  logic [NUM_EP-1:0]      hit;
  logic [NUM_EP-1:0]      dup_vec;

  usb_ep_cpu_port #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .views     (views),
    .cfg_wr    (cfg_wr),
    .reg_rdata (reg_rdata)
  );

  usb_ep_event_decode #(.NUM_EP(NUM_EP), .EPN_W(EPN_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pkt_stb (pkt_stb),
    .pkt_ep  (pkt_ep),
    .bus_rst (bus_rst),
    .hit     (hit)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usb_ep_entry u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rst  (bus_rst),
      .cfg_wr   (cfg_wr[i]),
      .cfg_en   (reg_wdata[EN_POS]),
      .cfg_dir  (reg_wdata[DIR_POS]),
      .cfg_kind (ep_kind_e'(reg_wdata[1:0])),
      .hit      (hit[i]),
      .pid_d1   (pkt_data1),
      .setup    (pkt_setup),
      .view     (views[i]),
      .dup      (dup_vec[i])
    );
  end

  assign pkt_dup = |dup_vec;

  // R5: a duplicate flag only ever accompanies a strobe
  a_r5_dup_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_dup |-> pkt_stb);
  // R10: no duplicate reported while bus reset is active
  a_r10_no_dup_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !pkt_dup);

endmodule

// File: tb/usb_ep_ctrl_bank_test.sv
`timescale 1ns/1ps
module usb_ep_ctrl_bank_test;
  localparam int N = 6;

  logic clk = 0, rst_n = 0, bus_rst = 0, reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic pkt_stb = 0, pkt_data1 = 0, pkt_setup = 0, pkt_dup;
  logic [2:0] pkt_ep = 0;

  usb_ep_ctrl_bank #(.NUM_EP(N), .EPN_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pkt_stb(pkt_stb), .pkt_ep(pkt_ep), .pkt_data1(pkt_data1),
    .pkt_setup(pkt_setup), .pkt_dup(pkt_dup));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_en[8], m_dir[8], m_tgl[8], m_exp[8];
  logic [1:0] m_kind[8];
  int m_epnum = 0;

  function automatic logic [7:0] exp_view(int e);
    if (e >= N) return 8'h00;
    return {m_en[e], 3'b000, m_tgl[e], m_dir[e], m_kind[e]};
  endfunction

  function automatic bit exp_dup(int e, bit pid, bit setup, bit bus);
    if (bus || e >= N || !m_en[e]) return 0;
    if (m_kind[e] == 2'b01) return 0;
    if (m_kind[e] == 2'b00 && setup) return 0;
    return pid != m_exp[e];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional register write and optional packet event
  task automatic op(bit wr, bit sel, logic [7:0] wd, bit stb, int ep,
                    bit pid, bit setup, bit bus, string req);
    bit ed;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; bus_rst = bus;
    pkt_stb = stb; pkt_ep = ep[2:0]; pkt_data1 = pid; pkt_setup = setup;
    #1;
    if (stb) begin
      ed = exp_dup(ep, pid, setup, bus);
      check(req, {7'b0, pkt_dup}, {7'b0, ed});
    end
    @(posedge clk);
    if (bus) begin
      for (int e = 0; e < 8; e++) begin
        m_en[e] = 0; m_dir[e] = 0; m_tgl[e] = 0; m_exp[e] = 0; m_kind[e] = 0;
      end
    end else begin
      if (stb && ep < N && m_en[ep]) begin
        if (m_kind[ep] == 2'b00 && setup) begin m_tgl[ep] = 0; m_exp[ep] = 1; end
        else begin m_tgl[ep] = pid; m_exp[ep] = !pid; end
      end
      if (wr && sel && m_epnum < N) begin
        m_en[m_epnum] = wd[7]; m_dir[m_epnum] = wd[2]; m_kind[m_epnum] = wd[1:0];
        if (wd[7]) begin m_tgl[m_epnum] = 0; m_exp[m_epnum] = 0; end
      end
    end
    if (wr && !sel) m_epnum = int'(wd[2:0]);
    @(negedge clk);
    reg_wr = 0; pkt_stb = 0; bus_rst = 0; pkt_setup = 0;
  endtask

  task automatic pick(int e);
    op(1, 0, 8'(e), 0, 0, 0, 0, 0, "");
  endtask

  task automatic cfg(int e, logic [7:0] d);
    pick(e); op(1, 1, d, 0, 0, 0, 0, 0, "");
  endtask

  task automatic peek(string req);
    reg_sel = 1; reg_wr = 0; #1;
    check(req, reg_rdata, exp_view(m_epnum));
  endtask

  task automatic rd(int e, string req);
    pick(e); peek(req);
  endtask

  task automatic pkt(int e, bit pid, bit setup, string req);
    op(0, 1, 0, 1, e, pid, setup, 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_sel = 0; #1;
    check("R1 epnum", reg_rdata, 8'h00);
    for (int e = 0; e < 8; e++) rd(e, "R1 reset byte");

    // R2 layout and reserved bits
    cfg(1, 8'hFF);
    peek("R2 write 0xFF");
    check("R2 literal", reg_rdata, 8'h87);
    // R3 epnum readback and unimplemented entry
    cfg(7, 8'h82);
    peek("R3 unimpl read");
    reg_sel = 0; #1; check("R3 epnum readback", reg_rdata, 8'h07);

    // R4/R5 bulk sequence on ep1
    cfg(1, 8'h82);
    pkt(1, 0, 0, "R5 first D0"); rd(1, "R4 after D0");
    pkt(1, 1, 0, "R5 D1");       rd(1, "R4 after D1");
    pkt(1, 1, 0, "R5 repeat D1 dup"); rd(1, "R4 after dup");
    pkt(1, 0, 0, "R5 D0 after dup");
    pkt(1, 1, 0, "R4 D1 again"); rd(1, "R4 tgl=1");
    // R8 disable write keeps history, then R9 ignored events
    op(1, 1, 8'h06, 0, 0, 0, 0, 0, ""); peek("R8 en=0 keeps toggle");
    pkt(1, 0, 0, "R9 disabled no dup"); rd(1, "R9 disabled unchanged");
    pkt(7, 1, 0, "R9 unimpl no dup");
    cfg(1, 8'h82); peek("R8 config resets toggle");
    pkt(1, 0, 0, "R8 D0 accepted after config");

    // R6 isochronous
    cfg(2, 8'h81);
    pkt(2, 0, 0, "R6 iso D0"); pkt(2, 0, 0, "R6 iso D0 repeat");
    pkt(2, 1, 0, "R6 iso D1"); pkt(2, 1, 0, "R6 iso D1 repeat");
    rd(2, "R6 iso toggle follows");

    // R7 control setup
    cfg(0, 8'h80);
    pkt(0, 0, 0, "R7 ctrl D0"); pkt(0, 1, 0, "R7 ctrl D1");
    pkt(0, 0, 1, "R7 setup no dup"); rd(0, "R7 setup clears toggle");
    pkt(0, 1, 0, "R7 D1 expected after setup");
    pkt(0, 1, 0, "R7 repeat D1 dup");
    pkt(0, 0, 1, "R7 setup again"); pkt(0, 0, 1, "R7 back-to-back setup");

    // R11 direction does not matter
    cfg(3, 8'h86); cfg(4, 8'h83);
    pkt(3, 1, 0, "R11 IN D1 dup"); pkt(4, 1, 0, "R11 OUT D1 dup");
    pkt(3, 0, 0, "R11 IN D0"); pkt(4, 0, 0, "R11 OUT D0");
    pkt(3, 0, 0, "R11 IN D0 dup"); pkt(4, 0, 0, "R11 OUT D0 dup");

    // R12 collision: config write and event in the same cycle
    cfg(1, 8'h82); pkt(1, 0, 0, "R12 prep");
    op(1, 1, 8'h82, 1, 1, 0, 0, 0, "R12 dup judged on old state");
    peek("R12 write wins toggle");
    pkt(1, 0, 0, "R12 D0 expected after collision");

    // R10 bus reset, with a strobe in the same cycle
    op(0, 1, 0, 1, 1, 1, 0, 1, "R10 no dup during bus reset");
    reg_sel = 0; #1; check("R10 epnum kept", reg_rdata, 8'(m_epnum));
    for (int e = 0; e < 8; e++) rd(e, "R10 cleared");

    // random phase
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      bit wr = 0, sel = 0, stb = 0, bus = 0;
      logic [7:0] wd = 8'($urandom());
      if (r < 10)      begin wr = 1; sel = 0; end
      else if (r < 25) begin wr = 1; sel = 1; end
      if (r >= 20 && r < 95) stb = 1;
      if (r >= 99) bus = 1;
      op(wr, sel, wd, stb, int'($urandom_range(0, 7)), 1'($urandom()),
         ($urandom_range(0, 7) == 0), bus, "R5 random dup");
      if ((k % 7) == 0) peek("R4 random readback");
    end
    for (int e = 0; e < 8; e++) rd(e, "R2 final readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule